// File: doc/BRIEF.md
# PHY reset and power-down controller

This block sequences reset and power-down for a compact Ethernet PHY management register set. It is clocked by the reference clock. It takes an active-low hardware reset pin, a strap value that carries the management port address, and a simple register write and read port. The register set is made up of three registers:

- A 16-bit control register, which holds a software-reset bit and a power-down bit.
- A status register, which holds three latching fields: a link-low latch, a fault-high latch and a peak-level latch.
- An extended register, which holds the captured address and spare read/write bits.

Three kinds of reset are handled, and each keeps a different part of the state:

- **Hardware or power-on reset.** This is the pin held low. It returns all registers to their defaults, powers the block down, and captures the strap address when the pin is released.
- **Software reset.** This starts when a one is written to control bit 15. It pulses the internal reset for two reference-clock cycles and restores register defaults. It does not power the block down and does not capture the address again.
- **Register power-down.** This is control bit 11 set to one. It gates the MAC-side outputs and the transmit-driver enable. It clears only the latching status fields and keeps every other register bit.

Top module: `phy_rstpd_ctrl`

## Requirements
- R1: A write to address 0 with data bit 15 set, accepted while `core_rst` is low, drives `core_rst` high for exactly the two cycles that follow the write edge.
- R2: After any reset, address 0 reads 0x0000, the spare bits [15:5] of address 2 read zero, and address 1 reads 0x0002.
- R3: `pwr_down` stays low for the whole software reset window, even if bit 11 was set before the reset.
- R4: The address field (bits [4:0] of address 2, which is also the `phy_addr` output) is loaded from `strap_addr` while a hardware reset is active. It is unchanged by a software reset.
- R5: Bit 15 of address 0 always reads zero, during and after a hardware reset as well as a software reset.
- R6: `pwr_down` is high whenever `rst_pin_n` is low (without waiting for a clock edge) or control bit 11 is one. `core_rst` is high whenever the pin is low.
- R7: While `pwr_down` is high, `mac_out` is all zero and `tx_drv_en` is low. Otherwise `mac_out` equals `mac_out_raw` and `tx_drv_en` is high.
- R8: While control bit 11 is set, address 0 and address 2 keep their written values. From the edge after bit 11 is set, the status register holds its default value 0x0002.
- R9: The status register (address 1) has three fields. Bit 1 latches a zero on `link_live`. Bit 0 latches a one on `fault_live`. Bits [7:4] hold the largest value seen on `lvl_live`. A cycle with `mgmt_re` high at address 1 returns the latched values, and the following edge reloads all three fields from the live inputs.
- R10: Writes that arrive during the software reset window have no effect. Reads in that window return the default values.
- R11: After `rst_pin_n` rises, `core_rst` and `pwr_down` stay high through the first clock edge and drop after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_pin_n | input | 1 | Hardware reset pin, active low |
| strap_addr | input | PHYAD_W | Strap value for the management address |
| mgmt_we | input | 1 | Register write strobe |
| mgmt_re | input | 1 | Register read strobe; a read of address 1 reloads the latches |
| mgmt_addr | input | 5 | Register address |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data for `mgmt_addr` (combinational) |
| link_live | input | 1 | Live link level, latched low |
| fault_live | input | 1 | Live fault level, latched high |
| lvl_live | input | LVL_W | Live level, peak latched |
| mac_out_raw | input | MAC_W | MAC-side outputs before gating |
| mac_out | output | MAC_W | Gated MAC-side outputs |
| core_rst | output | 1 | Internal reset, active high |
| pwr_down | output | 1 | Power-down indication |
| tx_drv_en | output | 1 | Transmit line driver enable |
| phy_addr | output | PHYAD_W | Captured management address |

## Verification
The assertions assume the following about the inputs:

- The reset pin changes away from the clock edge.
- A software reset write is recognised only while `core_rst` is low.
- The pin is not released in the same cycle as a software reset write.

The stimulus meets these conditions. It changes every input a few nanoseconds after the rising edge. It issues software reset writes only after `core_rst` has fallen. It holds the pin low across several edges at each hardware reset. Within those limits, a behavioural model in the bench predicts every output on every cycle, including writes aimed into the reset window and power-down entered before a software reset.

// File: rtl/phy_rstpd_pkg.sv
package phy_rstpd_pkg;
    localparam int REG_W      = 16;
    localparam int REG_AW     = 5;

    localparam logic [REG_AW-1:0] RA_CTRL = 5'd0;
    localparam logic [REG_AW-1:0] RA_STAT = 5'd1;
    localparam logic [REG_AW-1:0] RA_EXT  = 5'd2;

    localparam int CB_SWRST   = 15;
    localparam int CB_PDN     = 11;

    localparam int SB_LH      = 0;
    localparam int SB_LL      = 1;
    localparam int SB_MAX_LSB = 4;

    localparam logic [REG_W-2:0] CTRL_DEF = '0;
    localparam logic             LL_DEF   = 1'b1;
    localparam logic             LH_DEF   = 1'b0;
endpackage

// File: rtl/phy_rstpd_sync.sv
module phy_rstpd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic ok
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = (sh_q << 1) | {{(STAGES-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign ok = sh_q[STAGES-1];
endmodule

// File: rtl/phy_rstpd_latch.sv
module phy_rstpd_latch
    import phy_rstpd_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             reload,
    input  logic             ll_in,
    input  logic             lh_in,
    input  logic [LVL_W-1:0] lvl_in,
    output logic             ll_out,
    output logic             lh_out,
    output logic [LVL_W-1:0] max_out
);
    typedef struct packed {
        logic             ll;
        logic             lh;
        logic [LVL_W-1:0] mx;
    } lat_t;

    localparam lat_t LAT_RST = '{ll: LL_DEF, lh: LH_DEF, mx: '0};

    lat_t d, q;

    always_comb begin
        d = q;
        if (clr) begin
            d = LAT_RST;
        end else if (reload) begin
            d.ll = ll_in;
            d.lh = lh_in;
            d.mx = lvl_in;
        end else begin
            d.ll = q.ll & ll_in;
            d.lh = q.lh | lh_in;
            if (lvl_in > q.mx) d.mx = lvl_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= LAT_RST;
        else        q <= d;
    end

    assign ll_out  = q.ll;
    assign lh_out  = q.lh;
    assign max_out = q.mx;
endmodule

// File: rtl/phy_rstpd_ctrl.sv
module phy_rstpd_ctrl
    import phy_rstpd_pkg::*;
#(
    parameter int PHYAD_W    = 5,
    parameter int LVL_W      = 4,
    parameter int MAC_W      = 8,
    parameter int SW_RST_CYC = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_pin_n,
    input  logic [PHYAD_W-1:0] strap_addr,
    input  logic               mgmt_we,
    input  logic               mgmt_re,
    input  logic [REG_AW-1:0]  mgmt_addr,
    input  logic [REG_W-1:0]   mgmt_wdata,
    output logic [REG_W-1:0]   mgmt_rdata,
    input  logic               link_live,
    input  logic               fault_live,
    input  logic [LVL_W-1:0]   lvl_live,
    input  logic [MAC_W-1:0]   mac_out_raw,
    output logic [MAC_W-1:0]   mac_out,
    output logic               core_rst,
    output logic               pwr_down,
    output logic               tx_drv_en,
    output logic [PHYAD_W-1:0] phy_addr
);
    localparam int SCR_W = REG_W - PHYAD_W;
    localparam int CNT_W = $clog2(SW_RST_CYC + 1);

    typedef struct packed {
        logic [REG_W-2:0] ctrl;
        logic [SCR_W-1:0] scr;
        logic [CNT_W-1:0] win;
    } st_t;

    localparam st_t ST_RST = '{ctrl: CTRL_DEF, scr: '0, win: '0};

    st_t st_d, st_q;
    logic [PHYAD_W-1:0] addr_d, addr_q;
    logic hw_ok, sw_hit, win_on, lat_clr, lat_reload;
    logic ll_v, lh_v;
    logic [LVL_W-1:0] mx_v;
    logic [REG_W-1:0] stat_word;

    phy_rstpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .pin_n (rst_pin_n),
        .ok    (hw_ok)
    );

    always_comb begin
        win_on     = (st_q.win != '0);
        sw_hit     = mgmt_we && (mgmt_addr == RA_CTRL) && mgmt_wdata[CB_SWRST] && !win_on;
        lat_clr    = sw_hit || win_on || st_q.ctrl[CB_PDN];
        lat_reload = mgmt_re && (mgmt_addr == RA_STAT) && !lat_clr;

        st_d = st_q;
        if (sw_hit) begin
            st_d      = ST_RST;
            st_d.win  = CNT_W'(SW_RST_CYC);
        end else if (win_on) begin
            st_d.win  = st_q.win - 1'b1;
        end else if (mgmt_we) begin
            case (mgmt_addr)
                RA_CTRL: st_d.ctrl = mgmt_wdata[REG_W-2:0];
                RA_EXT:  st_d.scr  = mgmt_wdata[REG_W-1:PHYAD_W];
                default: ;
            endcase
        end

        addr_d = hw_ok ? addr_q : strap_addr;
    end

    always_ff @(posedge clk or negedge hw_ok) begin
        if (!hw_ok) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        addr_q <= addr_d;
    end

    phy_rstpd_latch #(.LVL_W(LVL_W)) u_lat (
        .clk     (clk),
        .rst_n   (hw_ok),
        .clr     (lat_clr),
        .reload  (lat_reload),
        .ll_in   (link_live),
        .lh_in   (fault_live),
        .lvl_in  (lvl_live),
        .ll_out  (ll_v),
        .lh_out  (lh_v),
        .max_out (mx_v)
    );

    always_comb begin
        stat_word                      = '0;
        stat_word[SB_LH]               = lh_v;
        stat_word[SB_LL]               = ll_v;
        stat_word[SB_MAX_LSB +: LVL_W] = mx_v;
        case (mgmt_addr)
            RA_CTRL: mgmt_rdata = {1'b0, st_q.ctrl};
            RA_STAT: mgmt_rdata = stat_word;
            RA_EXT:  mgmt_rdata = {st_q.scr, addr_q};
            default: mgmt_rdata = '0;
        endcase

        pwr_down  = !hw_ok || st_q.ctrl[CB_PDN];
        core_rst  = !hw_ok || win_on;
        tx_drv_en = !pwr_down;
        mac_out   = pwr_down ? '0 : mac_out_raw;
        phy_addr  = addr_q;
    end
endmodule

// File: rtl/phy_rstpd_chk.sv
module phy_rstpd_chk #(
    parameter int PHYAD_W = 5,
    parameter int MAC_W   = 8,
    parameter int SW_RST_CYC = 2
) (
    input logic               clk,
    input logic               rst_pin_n,
    input logic               mgmt_we,
    input logic [4:0]         mgmt_addr,
    input logic               sw_bit,
    input logic [15:0]        mgmt_rdata,
    input logic [MAC_W-1:0]   mac_out,
    input logic               core_rst,
    input logic               pwr_down,
    input logic               tx_drv_en,
    input logic [PHYAD_W-1:0] phy_addr
);
    int  win_cnt;
    logic acc;

    assign acc = mgmt_we && (mgmt_addr == 5'd0) && sw_bit && !core_rst;

    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n)       win_cnt <= 0;
        else if (acc)         win_cnt <= SW_RST_CYC;
        else if (win_cnt != 0) win_cnt <= win_cnt - 1;
    end

    p_sw_enter_r1: assert property (@(posedge clk) disable iff (!rst_pin_n)
        acc |=> core_rst);
    p_sw_window_r1: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (win_cnt != 0) |-> core_rst);
    p_sw_exit_r1: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (win_cnt == 0 && $past(win_cnt) == 1) |-> !core_rst);
    p_no_pd_sw_r3: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (win_cnt != 0) |-> !pwr_down);
    p_addr_kept_r4: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (win_cnt != 0) |-> $stable(phy_addr));
    p_bit15_zero_r5: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (mgmt_addr == 5'd0) |-> !mgmt_rdata[15]);
    p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
        pwr_down |-> (mac_out == '0) && !tx_drv_en);
    p_gate_on_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
        !pwr_down |-> tx_drv_en);
    p_lat_reinit_r8: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (pwr_down && $past(pwr_down) && !core_rst && mgmt_addr == 5'd1) |-> mgmt_rdata == 16'h0002);
    p_win_read_r10: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (win_cnt != 0 && mgmt_addr == 5'd0) |-> mgmt_rdata == 16'h0000);
    p_release_r11: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $rose(rst_pin_n) |-> core_rst && pwr_down);

    always @(negedge clk) begin
        if (!rst_pin_n) begin
            p_pin_pd_r6: assert (pwr_down && core_rst && !tx_drv_en);
        end
    end
endmodule

bind phy_rstpd_ctrl phy_rstpd_chk #(
    .PHYAD_W(PHYAD_W), .MAC_W(MAC_W), .SW_RST_CYC(SW_RST_CYC)
) u_chk (
    .clk        (clk),
    .rst_pin_n  (rst_pin_n),
    .mgmt_we    (mgmt_we),
    .mgmt_addr  (mgmt_addr),
    .sw_bit     (mgmt_wdata[15]),
    .mgmt_rdata (mgmt_rdata),
    .mac_out    (mac_out),
    .core_rst   (core_rst),
    .pwr_down   (pwr_down),
    .tx_drv_en  (tx_drv_en),
    .phy_addr   (phy_addr)
);

// File: tb/sim_phy_rstpd_ctrl.sv
`timescale 1ns/1ps
module sim_phy_rstpd_ctrl;
    logic        clk = 1'b0;
    logic        rst_pin_n = 1'b1;
    logic [4:0]  strap_addr = 5'h0A;
    logic        mgmt_we = 1'b0, mgmt_re = 1'b0;
    logic [4:0]  mgmt_addr = '0;
    logic [15:0] mgmt_wdata = '0;
    logic [15:0] mgmt_rdata;
    logic        link_live = 1'b1, fault_live = 1'b0;
    logic [3:0]  lvl_live = '0;
    logic [7:0]  mac_out_raw = 8'hA5;
    logic [7:0]  mac_out;
    logic        core_rst, pwr_down, tx_drv_en;
    logic [4:0]  phy_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    phy_rstpd_ctrl u0 (
        .clk(clk), .rst_pin_n(rst_pin_n), .strap_addr(strap_addr),
        .mgmt_we(mgmt_we), .mgmt_re(mgmt_re), .mgmt_addr(mgmt_addr),
        .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata),
        .link_live(link_live), .fault_live(fault_live), .lvl_live(lvl_live),
        .mac_out_raw(mac_out_raw), .mac_out(mac_out), .core_rst(core_rst),
        .pwr_down(pwr_down), .tx_drv_en(tx_drv_en), .phy_addr(phy_addr)
    );

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_h = 0, m_ctrl = 0, m_scr = 0, m_addr = 0, m_win = 0, m_max = 0;
    bit m_ll = 1, m_lh = 0;

    task automatic m_defaults();
        m_ctrl = 0; m_scr = 0; m_win = 0; m_ll = 1; m_lh = 0; m_max = 0;
    endtask

    always @(negedge rst_pin_n) begin
        m_h = 0;
        m_defaults();
    end

    always @(posedge clk) begin
        bit acc, clr;
        if (!rst_pin_n || m_h < 2) begin
            m_addr = strap_addr;
            m_defaults();
            if (rst_pin_n) m_h++;
        end else begin
            acc = mgmt_we && mgmt_addr == 0 && mgmt_wdata[15] && m_win == 0;
            clr = acc || m_win != 0 || m_ctrl[11];
            if (clr) begin
                m_ll = 1; m_lh = 0; m_max = 0;
            end else if (mgmt_re && mgmt_addr == 1) begin
                m_ll = link_live; m_lh = fault_live; m_max = lvl_live;
            end else begin
                m_ll = m_ll & link_live;
                m_lh = m_lh | fault_live;
                if (lvl_live > m_max) m_max = lvl_live;
            end
            if (acc) begin
                m_ctrl = 0; m_scr = 0; m_win = 2;
            end else if (m_win != 0) begin
                m_win--;
            end else if (mgmt_we) begin
                if (mgmt_addr == 0) m_ctrl = mgmt_wdata & 16'h7FFF;
                if (mgmt_addr == 2) m_scr = mgmt_wdata >> 5;
            end
        end
    end

    function automatic int m_rdata();
        case (mgmt_addr)
            5'd0: return m_ctrl;
            5'd1: return (m_max << 4) | (int'(m_ll) << 1) | int'(m_lh);
            5'd2: return (m_scr << 5) | m_addr;
            default: return 0;
        endcase
    endfunction

    // cycle compare against the model, away from the edge
    always @(posedge clk) begin
        bit ok, e_pd;
        #15;
        if (!done) begin
            ok   = rst_pin_n && m_h >= 2;
            e_pd = !ok || m_ctrl[11];
            chk("R1 core_rst", core_rst, (!ok || m_win != 0));
            chk("R6 pwr_down", pwr_down, e_pd);
            chk("R7 tx_drv_en", tx_drv_en, !e_pd);
            chk("R7 mac_out", mac_out, e_pd ? 0 : mac_out_raw);
            chk("R4 phy_addr", phy_addr, m_addr);
            chk("R9 rdata", mgmt_rdata, m_rdata());
        end
    end

    task automatic tick();
        @(posedge clk);
        #4;
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        mgmt_we = 1; mgmt_addr = a; mgmt_wdata = d;
        tick();
        mgmt_we = 0;
    endtask

    task automatic rd(logic [4:0] a, int exp, string req);
        mgmt_re = 1; mgmt_addr = a;
        #8;
        chk(req, mgmt_rdata, exp);
        tick();
        mgmt_re = 0;
    endtask

    initial begin
        #1 rst_pin_n = 0;
        repeat (3) tick();
        chk("R6 pin low pwr_down", pwr_down, 1);
        chk("R6 pin low core_rst", core_rst, 1);
        chk("R7 pin low tx_drv_en", tx_drv_en, 0);
        rst_pin_n = 1;
        tick();
        chk("R11 one edge after release", core_rst, 1);
        chk("R11 pwr_down one edge after release", pwr_down, 1);
        tick();
        chk("R11 two edges after release", core_rst, 0);
        chk("R4 strap captured", phy_addr, 5'h0A);
        rd(0, 16'h0000, "R2 ctrl reset value");
        rd(1, 16'h0002, "R2 status reset value");

        wr(0, 16'h1234);
        rd(0, 16'h1234, "R8 ctrl write");
        wr(2, 16'hFFE0);
        rd(2, 16'hFFEA, "R4 ext register");

        // latching fields
        link_live = 0; tick(); link_live = 1;
        fault_live = 1; tick(); fault_live = 0;
        lvl_live = 3; tick(); lvl_live = 9; tick(); lvl_live = 2; tick();
        rd(1, 16'h0091, "R9 latched values");
        rd(1, 16'h0022, "R9 reloaded values");

        // register power-down
        wr(0, 16'h1A34);
        chk("R6 bit11 pwr_down", pwr_down, 1);
        chk("R7 mac gated", mac_out, 0);
        chk("R7 tx disabled", tx_drv_en, 0);
        fault_live = 1; lvl_live = 5;
        tick();
        rd(1, 16'h0002, "R8 latches reinit");
        rd(0, 16'h1A34, "R8 ctrl kept");
        rd(2, 16'hFFEA, "R8 ext kept");
        fault_live = 0; lvl_live = 0;
        wr(0, 16'h1234);
        chk("R7 mac passes", mac_out, 8'hA5);
        chk("R7 tx enabled", tx_drv_en, 1);

        // software reset
        strap_addr = 5'h15;
        wr(0, 16'h8000);
        chk("R1 window cycle 1", core_rst, 1);
        chk("R3 no power-down", pwr_down, 0);
        mgmt_we = 1; mgmt_addr = 0; mgmt_wdata = 16'h0042;
        #8;
        chk("R10 read in window", mgmt_rdata, 16'h0000);
        tick();
        mgmt_we = 0;
        chk("R1 window cycle 2", core_rst, 1);
        tick();
        chk("R1 window over", core_rst, 0);
        rd(0, 16'h0000, "R10 write ignored, R2 ctrl cleared");
        rd(2, 16'h000A, "R4 address kept, R2 spare cleared");
        rd(1, 16'h0002, "R2 status default");

        // software reset while powered down by register
        wr(0, 16'h0800);
        chk("R6 bit11 set", pwr_down, 1);
        wr(0, 16'h8000);
        chk("R3 pd dropped by sw reset", pwr_down, 0);
        chk("R1 sw reset while pd", core_rst, 1);
        tick(); tick();

        // second hardware reset
        rst_pin_n = 0;
        mgmt_addr = 0;
        #8;
        chk("R5 bit15 during hw reset", mgmt_rdata[15], 0);
        chk("R6 async pwr_down", pwr_down, 1);
        tick(); tick();
        rst_pin_n = 1;
        tick(); tick();
        chk("R4 new strap captured", phy_addr, 5'h15);
        rd(0, 16'h0000, "R5 bit15 after hw reset");
        tick();

        done = 1;
        #20;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        done = 1;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule